// File: doc/BRIEF.md
# IDE Block-Transfer Address Sequencer

This block produces the word addresses in local memory for a block transfer to or from an IDE-style port. Software uses a small register bus to program three values: a 16-bit byte address where the transfer begins, a 16-bit byte address of the last word, and a 3-bit timing-mode field. A write of the go bit then starts the transfer. From then on the sequencer offers one word address per beat on a valid/ready handshake. It advances only when the port side accepts a beat, and it raises a one-cycle done pulse once the last word has been taken.

The internal counter steps only address bits [13:1]. The upper two bits come from the start address and are frozen for the whole run, so a transfer never leaves its 16-Kbyte window. If the end address lies below the start address inside the window, the counter wraps from the top of the window to its base. The end address is inclusive, so equal start and end addresses give a single word.

Control is a three-state machine. `ST_IDLE` waits for go. `ST_RUN` offers addresses while busy. `ST_DONE` is the single cycle that carries the done pulse. The transitions are as follows. IDLE→RUN is taken on go with an enabled mode. RUN→RUN is taken on every beat that is not the last. RUN→DONE is taken when the beat at the end address is accepted. DONE→RUN is taken on a go with an enabled mode during the done cycle. DONE→IDLE is taken otherwise. IDLE→IDLE is taken on no go, or on a go with a disabled mode.

Top module: `ide_blk_seq`

## Requirements
- R1: After reset, all three programmed registers and the control word read 0, and `busy`, `done` and `addr_valid` are low.
- R2: Register select 0 holds the start address and select 1 holds the end address; both are 16 bits wide and read back exactly as written. Select 2 holds the mode in bits [2:0], and its bits [15:3] always read 0. Reading select 3 returns `done` in bit 1 and `busy` in bit 0; writing select 3 with bit 0 set is the go command.
- R3: Bit 0 of both addresses is ignored. Every offered address has bit 0 clear, so an odd start address begins at the even word below it.
- R4: Addresses start at the start word and rise by 2 per accepted beat. The last beat is the word at the end address. The beat count is ((end[13:1] − start[13:1]) mod 8192) + 1.
- R5: When the start and end word addresses are equal, exactly one beat is offered.
- R6: Bits [15:14] of every offered address equal bits [15:14] of the start address, and those bits of the end address are ignored. Bits [13:1] wrap from 0x1FFF to 0 when the end address lies below the start address.
- R7: While `addr_valid` is high and `addr_ready` is low, `mem_addr` and `addr_valid` hold. The address advances only on a cycle where both are high.
- R8: In the cycle after the last beat is accepted, `done` is high for exactly one cycle, and `busy` and `addr_valid` are low in that cycle.
- R9: A go command has no effect when the mode is 000 (disabled) or a reserved value (110 or 111); `busy` stays low. Modes 001 to 101 are enabled.
- R10: While busy, writes to the start and end registers are stored and read back, but the running transfer keeps the values latched at go. A go while busy is ignored.
- R11: A go with an enabled mode is accepted in the done cycle or in any idle cycle, and `busy` is high in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 start, 1 end, 2 mode, 3 control |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_sel` (combinational) |
| mem_addr | output | 16 | Word address offered for the current beat |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Port side accepts the offered address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench chooses address pairs that expose the corners of the window arithmetic. An odd start address checks the bit-0 masking; a design that kept bit 0 would offer odd addresses. An end address below the start checks the wrap; a design that stepped all 16 bits would carry into bit 14 and leave the window. An end address whose top bits differ from the start checks that the window bits come only from the start; a design that used the end's top bits would never match the end and would run on. Equal start and end addresses check the inclusive end, where an exclusive compare gives zero or 8192 beats. The bench also stalls `addr_ready` to show that the address holds, rewrites the registers and repeats go in mid-run, which a design without latched values would follow, and issues go with disabled or reserved modes, which must leave the block idle.

// File: rtl/ide_seq_pkg.sv
package ide_seq_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_END   = 2'd1;
    localparam logic [1:0] SEL_MODE  = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    localparam logic [MODE_W-1:0] MODE_OFF    = 3'b000;
    localparam logic [MODE_W-1:0] MODE_LAST_OK = 3'b101;

    function automatic logic mode_enabled(input logic [MODE_W-1:0] m);
        return (m != MODE_OFF) && (m <= MODE_LAST_OK);
    endfunction

endpackage

// File: rtl/ide_seq_regs.sv
module ide_seq_regs
    import ide_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [AW-1:0]     reg_wdata,
    input  logic              busy,
    input  logic              done,
    output logic [AW-1:0]     reg_rdata,
    output logic [AW-1:0]     start_q,
    output logic [AW-1:0]     end_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              go
);

    localparam int PAD_MODE = AW - MODE_W;
    localparam int PAD_CTRL = AW - 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            mode_q  <= MODE_OFF;
        end else if (reg_we) begin
            unique case (reg_sel)
                SEL_START: start_q <= reg_wdata;
                SEL_END:   end_q   <= reg_wdata;
                SEL_MODE:  mode_q  <= reg_wdata[MODE_W-1:0];
                SEL_CTRL:  ;
                default:   ;
            endcase
        end
    end

    assign go = reg_we && (reg_sel == SEL_CTRL) && reg_wdata[0];

    always_comb begin
        unique case (reg_sel)
            SEL_START: reg_rdata = start_q;
            SEL_END:   reg_rdata = end_q;
            SEL_MODE:  reg_rdata = {{PAD_MODE{1'b0}}, mode_q};
            SEL_CTRL:  reg_rdata = {{PAD_CTRL{1'b0}}, done, busy};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ide_seq_ctr.sv
module ide_seq_ctr #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] first_val,
    input  logic [CW-1:0] last_val,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          at_last
);

    logic [CW-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            last_q <= '0;
        end else if (load) begin
            cnt    <= first_val;
            last_q <= last_val;
        end else if (step) begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == last_q);

endmodule

// File: rtl/ide_seq_fsm.sv
module ide_seq_fsm
    import ide_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic mode_ok,
    input  logic ready,
    input  logic at_last,
    output logic load,
    output logic step,
    output logic valid,
    output logic busy,
    output logic done
);

    seq_state_t state_q, state_d;
    logic       start_ok;

    assign start_ok = go && mode_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start_ok ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = (ready && at_last) ? ST_DONE : ST_RUN;
            ST_DONE: state_d = start_ok ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load  = 1'b0;
        step  = 1'b0;
        valid = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start_ok;
            ST_RUN: begin
                valid = 1'b1;
                busy  = 1'b1;
                step  = ready;
            end
            ST_DONE: begin
                done = 1'b1;
                load = start_ok;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ide_blk_seq.sv
module ide_blk_seq
    import ide_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int WW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          addr_valid,
    input  logic          addr_ready,
    output logic          busy,
    output logic          done
);

    localparam int CW   = WW - 1;
    localparam int HI_W = AW - WW;

    logic [AW-1:0]     start_q, end_q;
    logic [MODE_W-1:0] mode_q;
    logic              go, load, step, at_last;
    logic [CW-1:0]     cnt;
    logic [HI_W-1:0]   hi_q;
    logic              unused_bits;

    ide_seq_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .done      (done),
        .reg_rdata (reg_rdata),
        .start_q   (start_q),
        .end_q     (end_q),
        .mode_q    (mode_q),
        .go        (go)
    );

    ide_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .mode_ok (mode_enabled(mode_q)),
        .ready   (addr_ready),
        .at_last (at_last),
        .load    (load),
        .step    (step),
        .valid   (addr_valid),
        .busy    (busy),
        .done    (done)
    );

    ide_seq_ctr #(.CW(CW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .first_val (start_q[WW-1:1]),
        .last_val  (end_q[WW-1:1]),
        .step      (step),
        .cnt       (cnt),
        .at_last   (at_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    hi_q <= '0;
        else if (load) hi_q <= start_q[AW-1:WW];
    end

    assign mem_addr    = {hi_q, cnt, 1'b0};
    assign unused_bits = ^{start_q[0], end_q[0], end_q[AW-1:WW]};

endmodule

// File: rtl/ide_blk_seq_chk.sv
module ide_blk_seq_chk #(
    parameter int AW = 16,
    parameter int WW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [1:0]    reg_sel,
    input logic [AW-1:0] reg_wdata,
    input logic [AW-1:0] mem_addr,
    input logic          addr_valid,
    input logic          addr_ready,
    input logic          busy,
    input logic          done,
    input logic [2:0]    mode_q
);

    logic go_cmd, mode_good;
    assign go_cmd    = reg_we && (reg_sel == 2'd3) && reg_wdata[0];
    assign mode_good = (mode_q != 3'd0) && (mode_q < 3'd6);

    p_even_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (mem_addr[0] == 1'b0));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_ready) |=>
            (!addr_valid || mem_addr[WW-1:1] == $past(mem_addr[WW-1:1]) + 1'b1));

    p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_ready) |=>
            (!addr_valid || $stable(mem_addr[AW-1:WW])));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(mem_addr)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !addr_valid));

    p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(addr_valid && addr_ready));

    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go_cmd && !busy && !mode_good) |=> !busy);

    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (go_cmd && !busy && mode_good) |=> busy);

endmodule

bind ide_blk_seq ide_blk_seq_chk #(.AW(AW), .WW(WW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .mem_addr   (mem_addr),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .busy       (busy),
    .done       (done),
    .mode_q     (mode_q)
);

// File: tb/ide_blk_seq_bench.sv
`timescale 1ns/1ps
module ide_blk_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [15:0] mem_addr;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic        busy, done;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    ide_blk_seq u_ide_blk_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
        .addr_valid(addr_valid), .addr_ready(addr_ready), .busy(busy), .done(done)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    // Runs one transfer and checks every offered address, the beat count and done.
    task automatic run_xfer(input logic [15:0] s, input logic [15:0] e,
                            input bit stall, input bit disturb, input string req);
        logic [12:0] lo;
        int exp_n, beats, bad, dstep;
        bit saw_done;
        lo = s[13:1];
        exp_n = int'(13'(e[13:1] - s[13:1])) + 1;
        beats = 0; bad = 0; dstep = 0; saw_done = 1'b0;
        wr(2'd0, s);
        wr(2'd1, e);
        wr(2'd3, 16'h0001);
        chk(busy === 1'b1, req, "busy after go", int'(busy), 1);
        for (int c = 0; c < 40000; c++) begin
            @(negedge clk);
            if (disturb) begin
                if (dstep == 0 && beats == 1) begin
                    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0102; dstep = 1;
                end else if (dstep == 1) begin
                    reg_sel = 2'd3; reg_wdata = 16'h0001; dstep = 2;
                end else if (dstep == 2) begin
                    reg_sel = 2'd0; reg_wdata = 16'h3000; dstep = 3;
                end else if (dstep == 3) begin
                    reg_we = 1'b0; dstep = 4;
                end
            end
            if (done) begin
                saw_done = 1'b1;
                addr_ready = 1'b0;
                chk(!busy && !addr_valid, "R8", "busy/valid in done cycle",
                    int'({busy, addr_valid}), 0);
                break;
            end
            if (addr_valid) begin
                if (mem_addr !== {s[15:14], lo, 1'b0}) begin
                    bad++;
                    if (bad == 1)
                        $display("FAIL %s address at beat %0d: actual=0x%0h expected=0x%0h",
                                 req, beats, mem_addr, {s[15:14], lo, 1'b0});
                end
                addr_ready = !stall || (c % 3 == 0);
                if (addr_ready) begin
                    beats++;
                    lo = lo + 13'd1;
                end
            end else begin
                addr_ready = 1'b0;
            end
        end
        chk(bad == 0, req, "address mismatches", bad, 0);
        if (bad != 0) n_errors += 0;
        chk(beats == exp_n, req, "beat count", beats, exp_n);
        chk(saw_done, "R8", "done seen", int'(saw_done), 1);
        @(negedge clk);
        chk(!done && !busy, "R8", "done is one cycle", int'({done, busy}), 0);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), d);
            chk(d == 16'h0, "R1", "register after reset", d, 0);
        end
        chk(!busy && !done && !addr_valid, "R1", "status after reset",
            int'({busy, done, addr_valid}), 0);
    endtask

    task automatic t_regs;
        logic [15:0] d;
        wr(2'd0, 16'hA5A5); rd(2'd0, d);
        chk(d == 16'hA5A5, "R2", "start readback", d, 16'hA5A5);
        wr(2'd1, 16'h5A5B); rd(2'd1, d);
        chk(d == 16'h5A5B, "R2", "end readback", d, 16'h5A5B);
        wr(2'd2, 16'hFFFF); rd(2'd2, d);
        chk(d == 16'h0007, "R2", "mode readback", d, 16'h0007);
        wr(2'd2, 16'h0003);
    endtask

    task automatic t_gate;
        logic [2:0] bad_modes [3] = '{3'd0, 3'd6, 3'd7};
        foreach (bad_modes[i]) begin
            wr(2'd2, {13'd0, bad_modes[i]});
            wr(2'd3, 16'h0001);
            chk(!busy && !addr_valid, "R9", "go with disabled mode", int'(busy), 0);
            @(negedge clk);
            chk(!busy, "R9", "still idle", int'(busy), 0);
        end
        wr(2'd2, 16'h0003);
    endtask

    task automatic t_disturb;
        logic [15:0] d;
        run_xfer(16'h0100, 16'h010E, 1'b1, 1'b1, "R10");
        rd(2'd1, d);
        chk(d == 16'h0102, "R10", "end written while busy", d, 16'h0102);
        rd(2'd0, d);
        chk(d == 16'h3000, "R10", "start written while busy", d, 16'h3000);
    endtask

    task automatic t_back_to_back;
        int beats2;
        beats2 = 0;
        wr(2'd0, 16'h0600);
        wr(2'd1, 16'h0600);
        addr_ready = 1'b1;
        wr(2'd3, 16'h0001);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(done, "R11", "first done", int'(done), 1);
        reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 16'h0001;
        @(negedge clk);
        reg_we = 1'b0;
        chk(busy && mem_addr == 16'h0600, "R11", "go in done cycle accepted",
            int'(busy), 1);
        for (int c = 0; c < 20; c++) begin
            if (done) break;
            if (addr_valid) beats2++;
            @(negedge clk);
        end
        addr_ready = 1'b0;
        chk(beats2 == 1, "R11", "second run beats", beats2, 1);
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        run_xfer(16'h1000, 16'h1010, 1'b0, 1'b0, "R4");
        run_xfer(16'h2001, 16'h2007, 1'b0, 1'b0, "R3");
        run_xfer(16'h0444, 16'h0444, 1'b0, 1'b0, "R5");
        run_xfer(16'h0444, 16'h0445, 1'b0, 1'b0, "R5");
        run_xfer(16'hBFFC, 16'h8002, 1'b0, 1'b0, "R6");
        run_xfer(16'h4010, 16'hC014, 1'b0, 1'b0, "R6");
        run_xfer(16'h0200, 16'h0208, 1'b1, 1'b0, "R7");
        t_gate();
        t_disturb();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule